// File: doc/BRIEF.md
# Zero-Address Operand Stack Engine

This block executes a stream of already-decoded stack instructions. It keeps a small register-based operand stack and a depth counter. Arithmetic names no operands: an add takes the two entries on top of the stack and leaves their sum there. Only two instructions reach data memory. A load-to-stack reads one memory word and places it on top of the stack. A store-from-stack removes the top entry and writes it to a memory word.

Instructions arrive over a valid/ready handshake, and the block accepts one only after the previous one has fully completed. Memory sits behind a single request/grant port. A read returns its word on the cycle after the grant, and a write takes effect on the granted cycle. Two sticky flags record a stack overflow and a stack underflow. An instruction that raises either flag leaves the stack exactly as it was.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset the depth is 0, both error flags are low, in_ready is high and no memory request is made.
- R2: Opcode 0 (load-to-stack) reads memory at in_addr, stores the word at the slot given by the current depth, then adds one to the depth. With an immediate grant it occupies two cycles: in_ready is low for exactly one cycle after acceptance.
- R3: Opcode 1 (store-from-stack) subtracts one from the depth and then writes the entry at the new depth to memory at in_addr. With an immediate grant it completes in the acceptance cycle.
- R4: Opcode 2 (add) replaces the two topmost entries with their sum, lowers the depth by one, completes in one cycle and makes no memory request.
- R5: The add result wraps modulo 2^32 and has no carry output.
- R6: A load-to-stack at a depth of 16 sets err_overflow, which stays set until reset, and leaves the depth and the stack contents unchanged.
- R7: A store-from-stack at depth 0, or an add below depth 2, sets err_underflow, which stays set until reset, and has no effect on memory, depth or stack contents.
- R8: A memory request that is not granted is held, with the same address and direction, until it is granted. A read word is taken on the cycle after its grant.
- R9: Only one instruction is in flight at a time. in_ready stays low until the current instruction completes. Opcode 3 is a no-op that completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Engine can accept an instruction |
| in_op | input | 2 | 0 load-to-stack, 1 store-from-stack, 2 add, 3 no-op |
| in_addr | input | ADDR_W | Memory word address for opcodes 0 and 1 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read grant |
| stk_depth | output | $clog2(DEPTH+1) | Current number of stack entries |
| err_overflow | output | 1 | Sticky overflow flag |
| err_underflow | output | 1 | Sticky underflow flag |

## Verification
Instruction acceptance and the memory request can fall in the same cycle. A load or store raises mem_req combinationally in the cycle it is accepted, so the acceptance edge can also be the grant edge. The bench provokes this by holding mem_gnt low across the acceptance of a load and then of a store. It judges the result by checking that the request stays up with the same address, that the depth does not move and memory does not change during the stall, and that the correct word lands once the grant arrives. The immediate-grant cases fix the cycle counts of the fast path.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      OP_PUSH = 2'd0,
      OP_POP  = 2'd1,
      OP_ADD  = 2'd2,
      OP_NOP  = 2'd3
   } stk_op_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_RDREQ,
      S_RDWAIT,
      S_WR
   } stk_state_e;
endpackage

// File: rtl/stk_regfile.sv
module stk_regfile #(
   parameter int DATA_W         = 32,
   parameter int DEPTH          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b
);
   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot[gi] <= '0;
            else if (wr_en && wr_idx == IDX_W'(gi))
               slot[gi] <= wr_data;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(gi))
               slot[gi] <= wr_data;
         end
      end
   end

   assign rd_data_a = slot[rd_idx_a];
   assign rd_data_b = slot[rd_idx_b];
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
   import stk_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_op,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rf_wr_en,
   output logic [IDX_W-1:0]  rf_wr_idx,
   output logic [DATA_W-1:0] rf_wr_data,
   output logic [IDX_W-1:0]  rf_idx_a,
   input  logic [DATA_W-1:0] rf_data_a,
   output logic [IDX_W-1:0]  rf_idx_b,
   input  logic [DATA_W-1:0] rf_data_b,
   output logic [PTR_W-1:0]  depth,
   output logic              ovf,
   output logic              unf
);
   localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
   localparam logic [PTR_W-1:0] TWO  = PTR_W'(2);
   localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

   stk_state_e        state, state_nx;
   logic [PTR_W-1:0]  depth_nx, depth_m1, depth_m2;
   logic [ADDR_W-1:0] hold_addr;
   stk_op_e           op;
   logic              accept, full, empty, has_two;
   logic              do_push, do_pop, do_add;

   assign op       = stk_op_e'(in_op);
   assign in_ready = (state == S_IDLE);
   assign accept   = in_valid && in_ready;
   assign full     = (depth == FULL);
   assign empty    = (depth == '0);
   assign has_two  = (depth >= TWO);
   assign do_push  = accept && op == OP_PUSH && !full;
   assign do_pop   = accept && op == OP_POP && !empty;
   assign do_add   = accept && op == OP_ADD && has_two;
   assign depth_m1 = depth - ONE;
   assign depth_m2 = depth - TWO;

   // memory side: first request cycle coincides with acceptance
   assign mem_req   = do_push || do_pop || state == S_RDREQ || state == S_WR;
   assign mem_we    = do_pop || state == S_WR;
   assign mem_addr  = (state == S_IDLE) ? in_addr : hold_addr;
   assign rf_idx_a  = depth_m1[IDX_W-1:0];
   assign rf_idx_b  = depth_m2[IDX_W-1:0];
   assign mem_wdata = rf_data_a;

   // stack write: read data lands at depth, add result at depth-2
   assign rf_wr_en   = do_add || state == S_RDWAIT;
   assign rf_wr_idx  = (state == S_RDWAIT) ? depth[IDX_W-1:0] : depth_m2[IDX_W-1:0];
   assign rf_wr_data = (state == S_RDWAIT) ? mem_rdata : rf_data_a + rf_data_b;

   always_comb begin
      state_nx = state;
      unique case (state)
         S_IDLE: begin
            if (do_push)     state_nx = mem_gnt ? S_RDWAIT : S_RDREQ;
            else if (do_pop) state_nx = mem_gnt ? S_IDLE : S_WR;
         end
         S_RDREQ:  if (mem_gnt) state_nx = S_RDWAIT;
         S_RDWAIT: state_nx = S_IDLE;
         S_WR:     if (mem_gnt) state_nx = S_IDLE;
         default:  state_nx = S_IDLE;
      endcase
   end

   always_comb begin
      depth_nx = depth;
      if (state == S_RDWAIT)
         depth_nx = depth + ONE;
      else if (do_add)
         depth_nx = depth_m1;
      else if ((do_pop || state == S_WR) && mem_gnt)
         depth_nx = depth_m1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         depth     <= '0;
         hold_addr <= '0;
         ovf       <= 1'b0;
         unf       <= 1'b0;
      end else begin
         state <= state_nx;
         depth <= depth_nx;
         if (accept)
            hold_addr <= in_addr;
         if (accept && op == OP_PUSH && full)
            ovf <= 1'b1;
         if (accept && ((op == OP_POP && empty) || (op == OP_ADD && !has_two)))
            unf <= 1'b1;
      end
   end
endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit #(
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 16,
   parameter int DEPTH          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = $clog2(DEPTH),
   localparam int PTR_W         = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_op,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [PTR_W-1:0]  stk_depth,
   output logic              err_overflow,
   output logic              err_underflow
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("stack_exec_unit: DEPTH must be at least 2");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("stack_exec_unit: DATA_W and ADDR_W must be positive");
   end

   logic              rf_wr_en;
   logic [IDX_W-1:0]  rf_wr_idx, rf_idx_a, rf_idx_b;
   logic [DATA_W-1:0] rf_wr_data, rf_data_a, rf_data_b;

   stk_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_addr(in_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .rf_idx_a(rf_idx_a), .rf_data_a(rf_data_a),
      .rf_idx_b(rf_idx_b), .rf_data_b(rf_data_b),
      .depth(stk_depth), .ovf(err_overflow), .unf(err_underflow)
   );

   stk_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rf_wr_en), .wr_idx(rf_wr_idx), .wr_data(rf_wr_data),
      .rd_idx_a(rf_idx_a), .rd_data_a(rf_data_a),
      .rd_idx_b(rf_idx_b), .rd_data_b(rf_data_b)
   );
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [PTR_W-1:0]  stk_depth,
   input logic              err_overflow,
   input logic              err_underflow
);
   // R6: depth never exceeds capacity
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      stk_depth <= PTR_W'(DEPTH));

   // R6: overflow flag is sticky
   a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |=> err_overflow);

   // R7: underflow flag is sticky
   a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_underflow |=> err_underflow);

   // R3: a memory write only happens with something on the stack
   a_r3_write_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> stk_depth != '0);

   // R8: an ungranted request is held unchanged
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R2 / R9: after a granted read the engine is busy for the data cycle
   a_r2_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_gnt) |=> !in_ready);

   // R9: a request made while idle belongs to an offered instruction
   a_r9_req_source: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && in_ready) |-> in_valid);

   // R4: depth moves by at most one per cycle
   a_r4_depth_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (stk_depth == $past(stk_depth) ||
                        stk_depth == $past(stk_depth) + PTR_W'(1) ||
                        stk_depth == $past(stk_depth) - PTR_W'(1)));
endmodule

bind stack_exec_unit stk_exec_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
   .stk_depth(stk_depth), .err_overflow(err_overflow), .err_underflow(err_underflow)
);

// File: tb/sim_stack_exec_unit.sv
module sim_stack_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = 2'd3;
   logic [15:0] in_addr = '0;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_gnt = 1'b1;
   logic [31:0] mem_rdata;
   logic [4:0]  stk_depth;
   logic        err_overflow, err_underflow;

   always #4 clk = ~clk; // 125 MHz

   stack_exec_unit u0 (.*);

   int n_chk = 0;
   int n_fail = 0;
   int busy_cnt;
   logic [31:0] mem [64];
   logic [31:0] rstk [16];
   int          rdepth;
   logic        rovf, runf;

   function automatic logic [31:0] memval(input int a);
      if (a == 50) return 32'hFFFF_FFFF;
      if (a == 51) return 32'h0000_0002;
      return a * 32'h0101_0101 + 32'h7;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= memval(i);
      end else if (mem_req && mem_gnt) begin
         if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[5:0]];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rdepth = 0; rovf = 1'b0; runf = 1'b0;
   endtask

   task automatic send(input logic [1:0] op, input logic [5:0] a);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_addr = {10'd0, a};
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      busy_cnt = 0;
      while (!in_ready) begin
         busy_cnt++;
         @(negedge clk);
      end
   endtask

   // reference model built from R2..R7, then comparison
   task automatic issue(input logic [1:0] op, input logic [5:0] a);
      send(op, a);
      wait_idle();
      case (op)
         2'd0: if (rdepth == 16) rovf = 1'b1;
               else begin rstk[rdepth] = memval(int'(a)); rdepth++; end
         2'd1: if (rdepth == 0) runf = 1'b1;
               else begin
                  rdepth--;
                  chk(mem[a] == rstk[rdepth], "R3 stored word", mem[a], rstk[rdepth]);
               end
         2'd2: if (rdepth < 2) runf = 1'b1;
               else begin rstk[rdepth-2] = rstk[rdepth-1] + rstk[rdepth-2]; rdepth--; end
         default: ;
      endcase
      chk(stk_depth == 5'(rdepth), "R2/R3/R4 depth", 32'(stk_depth), rdepth);
      chk(err_overflow == rovf, "R6 overflow flag", 32'(err_overflow), 32'(rovf));
      chk(err_underflow == runf, "R7 underflow flag", 32'(err_underflow), 32'(runf));
   endtask

   // {op, addr, expected depth}
   localparam logic [12:0] VEC [13] = '{
      {2'd0, 6'd1,  5'd1}, {2'd0, 6'd2,  5'd2}, {2'd0, 6'd3,  5'd3},
      {2'd2, 6'd0,  5'd2}, {2'd3, 6'd9,  5'd2}, {2'd1, 6'd40, 5'd1},
      {2'd0, 6'd4,  5'd2}, {2'd2, 6'd0,  5'd1}, {2'd1, 6'd41, 5'd0},
      {2'd0, 6'd5,  5'd1}, {2'd0, 6'd6,  5'd2}, {2'd1, 6'd42, 5'd1},
      {2'd1, 6'd43, 5'd0}
   };

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1
      chk(stk_depth == 0, "R1 depth", 32'(stk_depth), 0);
      chk(!err_overflow && !err_underflow, "R1 flags", {err_overflow, err_underflow}, 0);
      chk(in_ready && !mem_req, "R1 idle", {in_ready, mem_req}, 32'h2);

      for (int i = 0; i < 13; i++) begin
         issue(VEC[i][12:11], VEC[i][10:5]);
         chk(stk_depth == VEC[i][4:0], "R9 table depth", 32'(stk_depth), 32'(VEC[i][4:0]));
      end
      chk(mem[9] == memval(9), "R9 no-op leaves memory", mem[9], memval(9));

      // R2 timing: one busy cycle after acceptance
      send(2'd0, 6'd8); wait_idle();
      chk(busy_cnt == 1, "R2 push cycles", busy_cnt, 1);
      rstk[rdepth] = memval(8); rdepth++;
      send(2'd0, 6'd9); wait_idle(); rstk[rdepth] = memval(9); rdepth++;
      // R4 timing and no memory access
      @(negedge clk); in_valid = 1'b1; in_op = 2'd2;
      #1 chk(!mem_req, "R4 no memory request", 32'(mem_req), 0);
      @(posedge clk); @(negedge clk); in_valid = 1'b0;
      wait_idle();
      chk(busy_cnt == 0, "R4 add cycles", busy_cnt, 0);
      rstk[0] = rstk[0] + rstk[1]; rdepth = 1;
      // R3 timing: done in acceptance cycle
      send(2'd1, 6'd44); wait_idle();
      chk(busy_cnt == 0, "R3 pop cycles", busy_cnt, 0);
      chk(mem[44] == memval(8) + memval(9), "R3 pop value", mem[44], memval(8) + memval(9));

      // R8: stalled grant on a push then a pop
      mem_gnt = 1'b0;
      send(2'd0, 6'd7);
      repeat (2) @(negedge clk);
      chk(mem_req && !mem_we && mem_addr == 16'd7, "R8 read held", mem_addr, 7);
      chk(stk_depth == 0 && !in_ready, "R8 no progress", 32'(stk_depth), 0);
      mem_gnt = 1'b1;
      wait_idle();
      chk(stk_depth == 1, "R8 depth after read", 32'(stk_depth), 1);
      mem_gnt = 1'b0;
      send(2'd1, 6'd45);
      repeat (2) @(negedge clk);
      chk(mem[45] == memval(45), "R8 write held back", mem[45], memval(45));
      chk(mem_req && mem_we && mem_addr == 16'd45, "R8 write held", mem_addr, 45);
      mem_gnt = 1'b1;
      wait_idle();
      chk(mem[45] == memval(7), "R8 write value", mem[45], memval(7));
      rdepth = 0;

      // R5 wraparound
      issue(2'd0, 6'd50); issue(2'd0, 6'd51); issue(2'd2, 6'd0); issue(2'd1, 6'd46);
      chk(mem[46] == 32'd1, "R5 wrap", mem[46], 1);

      // R6 overflow
      for (int k = 0; k < 16; k++) issue(2'd0, 6'(10 + k));
      issue(2'd0, 6'd30);
      chk(err_overflow && stk_depth == 16, "R6 overflow", 32'(stk_depth), 16);
      issue(2'd1, 6'd47);
      chk(mem[47] == memval(25), "R6 stack unchanged", mem[47], memval(25));
      issue(2'd2, 6'd0);
      chk(err_overflow, "R6 sticky", 32'(err_overflow), 1);

      // R7 add with one entry
      do_reset();
      issue(2'd0, 6'd5);
      issue(2'd2, 6'd0);
      chk(err_underflow && stk_depth == 1, "R7 add underflow", 32'(stk_depth), 1);
      issue(2'd1, 6'd48);
      chk(mem[48] == memval(5), "R7 add had no effect", mem[48], memval(5));
      // R1 flags clear after reset, then R7 pop on empty
      do_reset();
      @(negedge clk);
      chk(!err_underflow && !err_overflow, "R1 flags cleared", {err_overflow, err_underflow}, 0);
      issue(2'd1, 6'd49);
      chk(mem[49] == memval(49), "R7 empty pop no write", mem[49], memval(49));
      issue(2'd3, 6'd0);
      chk(err_underflow, "R7 sticky", 32'(err_underflow), 1);

      finish_run();
   end
endmodule